// File: doc/BRIEF.md
# Drive-Side Host Interrupt Generator

This block produces the interrupt line that a disk drive raises toward its host. It keeps one pending-interrupt flag. Two kinds of event set the flag: the completion of a command, and the start of a data block during a programmed-I/O transfer. Hardware reset and soft reset clear it. The host-side accesses that acknowledge an interrupt also clear it: writing a command code and reading the primary status register. The flag reaches the pin only while this drive is the selected one and the host has not disabled interrupts.

During a programmed-I/O command the block counts the sectors made ready and groups them into data blocks. A block is a programmable number of sectors, one by default. An interrupt is requested at the first sector of every block. Commands flagged as write-type skip the request for their first block, because the host starts sending those data without waiting. Sector buffering and command decoding are done elsewhere. This block sees only one pulse per ready sector and one write-type flag, which it samples together with the command write.

Top module: `drv_intrq_top`

## Requirements
- R1: `intrq_o` is high exactly when the pending flag is set, `dev_sel_i` is 1 and `irq_dis_i` is 0. Deselecting the drive or setting the disable bit keeps the pending flag, and the output returns once both conditions allow it again.
- R2: A `cmd_done_i` pulse sets the pending flag, and it shows on `intrq_o` in the cycle after the clock edge that samples the pulse.
- R3: A `hw_reset_i` pulse clears the pending flag, returns the block size to 1 sector and ends block tracking. It wins over any same-cycle set event.
- R4: A `soft_reset_i` pulse clears the pending flag and ends block tracking. It wins over any same-cycle set event.
- R5: A `cmd_wr_i` pulse clears the pending flag.
- R6: A `stat_rd_i` pulse clears the pending flag. An `alt_stat_rd_i` pulse leaves it unchanged.
- R7: When a set event (command completion or block start) and a `cmd_wr_i` or `stat_rd_i` pulse fall in the same cycle, the flag ends up set.
- R8: After a `cmd_wr_i`, sector pulses are counted from 0. A sector whose index within the command is a multiple of the block size requests an interrupt, and the other sectors do not.
- R9: If `wr_type_i` was 1 at the command write, the sectors of the first block request no interrupt. Later blocks behave as in R8.
- R10: The block size resets to 1. A `blk_cfg_wr_i` pulse with a non-zero `blk_cfg_i` loads that size and restarts the sector count. A value of 0 is ignored and the size is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_sel_i | input | 1 | This drive is currently selected |
| irq_dis_i | input | 1 | Interrupt-disable bit from the device control register |
| hw_reset_i | input | 1 | Hardware reset event pulse |
| soft_reset_i | input | 1 | Soft-reset bit set event pulse |
| cmd_wr_i | input | 1 | Host wrote the command register |
| wr_type_i | input | 1 | The command being written is write-type |
| stat_rd_i | input | 1 | Host read the status register |
| alt_stat_rd_i | input | 1 | Host read the alternate status register |
| sec_rdy_i | input | 1 | One sector ready for PIO transfer |
| cmd_done_i | input | 1 | Command completed |
| blk_cfg_wr_i | input | 1 | Load a new block size |
| blk_cfg_i | input | CNT_W | Block size in sectors |
| intrq_o | output | 1 | Interrupt request to the host |

## Verification
The bench builds the block with CNT_W = 4, so the largest block size is 15 sectors. With that width, the bench can run a 15-sector block and the sector after it with the full wrap of the sector counter, and stay short. Read-type and write-type commands are run at sizes 1, 4 and 15. Each sector is checked against the index rule, and the interrupt is acknowledged between sectors. Every clear event is tried alone and together with a set event, and the selection and disable gating is toggled while a flag is pending.

// File: rtl/drv_irq_pkg.sv
package drv_irq_pkg;

  localparam int unsigned DEF_CNT_W = 8;

  typedef struct packed {
    logic set;       // completion or block start
    logic clr_host;  // command write or status read
    logic clr_rst;   // hardware or soft reset
  } irq_evt_t;

endpackage

// File: rtl/drv_irq_rst_sync.sv
module drv_irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/drv_irq_blk_track.sv
module drv_irq_blk_track #(
  parameter int unsigned CNT_W = drv_irq_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_rst_i,
  input  logic             sw_rst_i,
  input  logic             cmd_wr_i,
  input  logic             wr_type_i,
  input  logic             sec_rdy_i,
  input  logic             cfg_wr_i,
  input  logic [CNT_W-1:0] cfg_val_i,
  output logic             blk_irq_o
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] blk_size_q, blk_size_d;
  logic [CNT_W-1:0] sec_cnt_q, sec_cnt_d;
  logic             first_q, first_d;
  logic             wr_cmd_q, wr_cmd_d;
  logic             size_en, cnt_en;
  logic             cfg_ok;
  logic [CNT_W-1:0] sec_inc;

  assign cfg_ok  = cfg_wr_i && (cfg_val_i != ZERO);
  assign sec_inc = sec_cnt_q + ONE;

  // block size register
  assign size_en = hw_rst_i || cfg_ok;
  always_comb begin
    blk_size_d = blk_size_q;
    if (hw_rst_i)    blk_size_d = ONE;
    else if (cfg_ok) blk_size_d = cfg_val_i;
  end

  // sector position within command
  assign cnt_en = hw_rst_i || sw_rst_i || cmd_wr_i || sec_rdy_i || cfg_ok;
  always_comb begin
    sec_cnt_d = sec_cnt_q;
    first_d   = first_q;
    wr_cmd_d  = wr_cmd_q;
    if (hw_rst_i || sw_rst_i) begin
      sec_cnt_d = ZERO;
      first_d   = 1'b0;
      wr_cmd_d  = 1'b0;
    end else if (cmd_wr_i) begin
      sec_cnt_d = ZERO;
      first_d   = 1'b1;
      wr_cmd_d  = wr_type_i;
    end else if (cfg_ok) begin
      sec_cnt_d = ZERO;
    end else if (sec_rdy_i) begin
      sec_cnt_d = (sec_inc >= blk_size_q) ? ZERO : sec_inc;
      if (sec_inc >= blk_size_q) first_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_size_q <= ONE;
      sec_cnt_q  <= ZERO;
      first_q    <= 1'b0;
      wr_cmd_q   <= 1'b0;
    end else begin
      if (size_en) blk_size_q <= blk_size_d;
      if (cnt_en) begin
        sec_cnt_q <= sec_cnt_d;
        first_q   <= first_d;
        wr_cmd_q  <= wr_cmd_d;
      end
    end
  end

  assign blk_irq_o = sec_rdy_i && !hw_rst_i && !sw_rst_i && !cmd_wr_i &&
                     (sec_cnt_q == ZERO) && !(first_q && wr_cmd_q);

  AST_CNT_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    sec_cnt_q < blk_size_q); // R8

  AST_SIZE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    blk_size_q != ZERO); // R10

  AST_ZERO_CFG_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_i && cfg_val_i == ZERO && !hw_rst_i) |=> $stable(blk_size_q)); // R10

  AST_HW_SIZE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rst_i |=> (blk_size_q == ONE)); // R3

endmodule

// File: rtl/drv_irq_pend.sv
module drv_irq_pend (
  input  logic                  clk,
  input  logic                  rst_n,
  input  drv_irq_pkg::irq_evt_t evt_i,
  output logic                  pend_o
);

  logic pend_q, pend_d, pend_en;

  assign pend_en = evt_i.set || evt_i.clr_host || evt_i.clr_rst;

  always_comb begin
    pend_d = pend_q;
    if (evt_i.clr_rst)       pend_d = 1'b0;
    else if (evt_i.set)      pend_d = 1'b1;
    else if (evt_i.clr_host) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  AST_SET_BEATS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.set && !evt_i.clr_rst) |=> pend_q); // R7

  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i.clr_rst |=> !pend_q); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_en |=> $stable(pend_q)); // R1

endmodule

// File: rtl/drv_intrq_top.sv
module drv_intrq_top #(
  parameter int unsigned CNT_W = drv_irq_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_sel_i,
  input  logic             irq_dis_i,
  input  logic             hw_reset_i,
  input  logic             soft_reset_i,
  input  logic             cmd_wr_i,
  input  logic             wr_type_i,
  input  logic             stat_rd_i,
  input  logic             alt_stat_rd_i,
  input  logic             sec_rdy_i,
  input  logic             cmd_done_i,
  input  logic             blk_cfg_wr_i,
  input  logic [CNT_W-1:0] blk_cfg_i,
  output logic             intrq_o
);

  logic                  rst_q_n;
  logic                  blk_irq;
  logic                  pend;
  drv_irq_pkg::irq_evt_t evt;

  drv_irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  drv_irq_blk_track #(.CNT_W(CNT_W)) u_blk (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .hw_rst_i  (hw_reset_i),
    .sw_rst_i  (soft_reset_i),
    .cmd_wr_i  (cmd_wr_i),
    .wr_type_i (wr_type_i),
    .sec_rdy_i (sec_rdy_i),
    .cfg_wr_i  (blk_cfg_wr_i),
    .cfg_val_i (blk_cfg_i),
    .blk_irq_o (blk_irq)
  );

  always_comb begin
    evt.set      = blk_irq || cmd_done_i;
    evt.clr_host = cmd_wr_i || stat_rd_i;
    evt.clr_rst  = hw_reset_i || soft_reset_i;
  end

  drv_irq_pend u_pend (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .evt_i  (evt),
    .pend_o (pend)
  );

  assign intrq_o = pend && dev_sel_i && !irq_dis_i;

  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cmd_done_i && !hw_reset_i && !soft_reset_i) |=> pend); // R2

  AST_HW_CLEARS: assert property (@(posedge clk) disable iff (!rst_q_n)
    hw_reset_i |=> !intrq_o); // R3

  AST_SW_CLEARS: assert property (@(posedge clk) disable iff (!rst_q_n)
    soft_reset_i |=> !intrq_o); // R4

  AST_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cmd_wr_i && !cmd_done_i) |=> !pend); // R5

  AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (stat_rd_i && !cmd_done_i && !sec_rdy_i) |=> !pend); // R6

  AST_ALT_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (alt_stat_rd_i && !stat_rd_i && !cmd_wr_i && !cmd_done_i && !sec_rdy_i &&
     !hw_reset_i && !soft_reset_i) |=> $stable(pend)); // R6

endmodule

// File: tb/drv_intrq_top_tb.sv
module drv_intrq_top_tb;

  localparam int unsigned W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         dev_sel, irq_dis, hw_rst, sw_rst, cmd_wr, wr_type;
  logic         stat_rd, alt_rd, sec_rdy, cmd_done, cfg_wr;
  logic [W-1:0] cfg_val;
  logic         intrq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2ns clk = ~clk;

  drv_intrq_top #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .dev_sel_i(dev_sel), .irq_dis_i(irq_dis),
    .hw_reset_i(hw_rst), .soft_reset_i(sw_rst), .cmd_wr_i(cmd_wr),
    .wr_type_i(wr_type), .stat_rd_i(stat_rd), .alt_stat_rd_i(alt_rd),
    .sec_rdy_i(sec_rdy), .cmd_done_i(cmd_done), .blk_cfg_wr_i(cfg_wr),
    .blk_cfg_i(cfg_val), .intrq_o(intrq)
  );

  task automatic chk(input logic exp, input string req);
    checks++;
    if (intrq !== exp) begin
      errors++;
      $display("FAIL %s intrq actual=%b expected=%b", req, intrq, exp);
    end
  endtask

  task automatic idle_all();
    hw_rst = 0; sw_rst = 0; cmd_wr = 0; wr_type = 0; stat_rd = 0;
    alt_rd = 0; sec_rdy = 0; cmd_done = 0; cfg_wr = 0; cfg_val = '0;
  endtask

  // inputs set after a falling edge stay for exactly one rising edge
  task automatic step();
    @(negedge clk);
    idle_all();
  endtask

  task automatic set_pending();
    cmd_done = 1; step();
  endtask

  task automatic t_reset();
    chk(1'b0, "R1 reset state");
  endtask

  task automatic t_gating();
    set_pending();                 chk(1'b1, "R2 done sets");
    dev_sel = 0; step();           chk(1'b0, "R1 deselected");
    dev_sel = 1; step();           chk(1'b1, "R1 reselected");
    irq_dis = 1; step();           chk(1'b0, "R1 disabled");
    irq_dis = 0; step();           chk(1'b1, "R1 enabled again");
  endtask

  task automatic t_clears();
    alt_rd = 1; step();            chk(1'b1, "R6 alt read keeps");
    stat_rd = 1; step();           chk(1'b0, "R6 status read clears");
    set_pending();
    cmd_wr = 1; step();            chk(1'b0, "R5 cmd write clears");
    set_pending();
    sw_rst = 1; step();            chk(1'b0, "R4 soft reset clears");
    set_pending();
    hw_rst = 1; step();            chk(1'b0, "R3 hw reset clears");
    cmd_done = 1; sw_rst = 1; step(); chk(1'b0, "R4 reset beats set");
    cmd_done = 1; hw_rst = 1; step(); chk(1'b0, "R3 reset beats set");
  endtask

  task automatic t_priority();
    cmd_done = 1; stat_rd = 1; step(); chk(1'b1, "R7 set beats status read");
    cmd_done = 1; cmd_wr = 1; step();  chk(1'b1, "R7 set beats cmd write");
    stat_rd = 1; step();               chk(1'b0, "R6 clear after R7");
  endtask

  // expected interrupt per sector computed from the index rule
  task automatic run_cmd(input bit wr, input int size, input int nsec,
                         input bit load);
    if (load) begin
      cfg_wr = 1; cfg_val = W'(size); step();
    end
    cmd_wr = 1; wr_type = wr; step();
    chk(1'b0, "R5 start of command");
    for (int i = 0; i < nsec; i++) begin
      logic e;
      e = ((i % size) == 0) && !(wr && i < size);
      sec_rdy = 1; step();
      chk(e, wr ? "R9 write-type block start" : "R8 block start");
      if (e) begin stat_rd = 1; step(); end
    end
  endtask

  task automatic t_zero_cfg();
    cfg_wr = 1; cfg_val = W'(3); step();
    cfg_wr = 1; cfg_val = '0; step();
    run_cmd(1'b0, 3, 7, 1'b0);     // size stays 3 (R10)
  endtask

  task automatic t_hw_size();
    cfg_wr = 1; cfg_val = W'(4); step();
    hw_rst = 1; step();
    run_cmd(1'b0, 1, 3, 1'b0);     // size back to 1 (R3)
  endtask

  task automatic t_set_with_block();
    cmd_wr = 1; step();
    sec_rdy = 1; stat_rd = 1; step(); chk(1'b1, "R7 block start beats read");
    stat_rd = 1; step();
  endtask

  initial begin
    #400us;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_all();
    dev_sel = 1; irq_dis = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_gating();
    t_clears();
    t_priority();
    run_cmd(1'b0, 1, 3, 1'b1);     // R8 size 1 read
    run_cmd(1'b0, 4, 9, 1'b1);     // R8 size 4 read, R10 load
    run_cmd(1'b1, 1, 3, 1'b1);     // R9 size 1 write
    run_cmd(1'b1, 4, 9, 1'b1);     // R9 size 4 write
    run_cmd(1'b0, 15, 16, 1'b1);   // R8 largest size
    run_cmd(1'b1, 15, 31, 1'b1);   // R9 largest size
    t_zero_cfg();
    t_hw_size();
    t_set_with_block();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule